// File: doc/BRIEF.md
# Serial Frame Start Controller

This block decides the clock cycle in which a parallel-to-serial shift engine begins a new outgoing frame. It picks one of two parallel data words, presents it together with a one-cycle start strobe, and then waits for the engine's done pulse. After that it waits a programmable idle gap before it will consider another start. The shifter and its bit-rate timing sit outside the block. The only link to them is the start strobe, the word to send, and the done pulse that comes back.

Two configuration bits set the start policy. The policy can be free-running, data-change driven, driven by the edge of a hardware trigger, or driven by either trigger or change. A comparison register keeps the last word actually sent, so that a change of the selected source can be detected. A separate one-cycle pulse reports each newly detected change. A trigger edge that arrives while a frame or its gap is running is held and served afterwards. A data change needs no separate latch, because the comparison against the stored word stays true until the word is sent.

Top module: `frame_start_ctrl`

## Requirements
- R1: After reset, start_o, chg_pulse_o and word_o are all zero, and the comparison register holds zero. In change mode, a zero source word therefore starts no frame.
- R2: The mode is {cfg_trig_en, cfg_chg_en}: 2'b00 is continuous, 2'b01 is change, 2'b10 is trigger and 2'b11 is trigger-or-change. In trigger-only mode a changed data word starts nothing.
- R3: In continuous mode, the next start_o appears exactly cfg_gap+1 cycles after the clock edge that samples eng_done high, with cfg_gap = 0 giving one cycle.
- R4: start_o is high for exactly one cycle. word_o takes the selected word in that cycle and holds it until the next start. No second start occurs until eng_done has been seen.
- R5: In change mode, a frame starts in the cycle after the selected word differs from the comparison register, while the block is idle. That register is loaded with the sent word at start, so one change gives one frame.
- R6: cfg_src_sel = 0 selects src_a and cfg_src_sel = 1 selects src_b, both for comparison and for sending.
- R7: With cfg_chg_en = 1, chg_pulse_o is high for one cycle, in the cycle after the selected word begins to differ from the comparison register.
- R8: In trigger mode, start_o rises two cycles after the active edge of hw_trig is applied. cfg_trig_fall = 0 selects the rising edge and 1 selects the falling edge. The opposite edge starts nothing.
- R9: With cfg_trig_en = 0, edges on hw_trig have no effect.
- R10: A trigger edge that arrives during a frame is held. Its start comes cfg_gap+1 cycles after the done edge, and it yields exactly one frame.
- R11: In trigger-or-change mode, either a data change alone or a trigger edge alone starts a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_trig_en | input | 1 | Trigger enable (mode bit 1) |
| cfg_chg_en | input | 1 | Change enable (mode bit 0) |
| cfg_src_sel | input | 1 | 0 selects src_a, 1 selects src_b |
| cfg_trig_fall | input | 1 | 0: rising trigger edge, 1: falling edge |
| cfg_gap | input | GAP_W | Idle cycles after done before a new start |
| src_a | input | DATA_W | Parallel data source A |
| src_b | input | DATA_W | Parallel data source B |
| hw_trig | input | 1 | Hardware trigger level |
| eng_done | input | 1 | Shift engine frame-complete pulse |
| start_o | output | 1 | One-cycle frame start strobe |
| word_o | output | DATA_W | Word for the shift engine to send |
| chg_pulse_o | output | 1 | One-cycle data-change indication |

## Verification
The bench builds the block with DATA_W = 16 and GAP_W = 4. A 4-bit gap keeps every gap interval within a few cycles, so the exact start cycle can be counted both for gap zero and for non-zero gaps. With 16-bit words the sources can differ in both halves, and switching the source to a word equal to the stored one shows that no change is seen across a selection switch. A stimulus table walks change mode one cycle at a time. Directed sequences cover the trigger polarity, a trigger held pending during a frame, the disabled trigger and the combined mode.

// File: rtl/frm_start_pkg.sv
// Package: shared state and mode encodings for the frame start controller.
// Assumes: mode value is {trigger enable, change enable}.
package frm_start_pkg;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_BUSY = 2'd1,
        FS_GAP  = 2'd2
    } fs_state_t;

    typedef enum logic [1:0] {
        MODE_CONT   = 2'b00,
        MODE_CHG    = 2'b01,
        MODE_TRIG   = 2'b10,
        MODE_EITHER = 2'b11
    } fs_mode_t;

endpackage

// File: rtl/fs_trig_edge.sv
// Module: detects the selected edge of the hardware trigger and holds it
// as pending until the controller consumes it with a start.
// Assumes: trig_in is synchronous to clk; a new edge wins over consume.
module fs_trig_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    input  logic fall_sel,
    input  logic enable,
    input  logic consume,
    output logic pending
);

    logic trig_q;
    logic edge_seen;

    // Purpose: remember last trigger level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_in;
    end

    // Purpose: pick the active edge by polarity.
    always_comb begin
        if (fall_sel) edge_seen = trig_q & ~trig_in;
        else          edge_seen = ~trig_q & trig_in;
    end

    // Purpose: hold a seen edge until it is served; drop all when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)         pending <= 1'b0;
        else if (!enable)   pending <= 1'b0;
        else if (edge_seen) pending <= 1'b1;
        else if (consume)   pending <= 1'b0;
    end

    p_trig_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !pending);

    p_rise_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !fall_sel && $rose(trig_in)) |=> pending);

    p_fall_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && fall_sel && $fell(trig_in)) |=> pending);

endmodule

// File: rtl/fs_change_track.sv
// Module: selects the source word, keeps the last sent word, flags a
// difference and emits a one-cycle pulse when a difference appears.
// Assumes: load is high only in the cycle a start is issued.
module fs_change_track #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic              sel,
    input  logic              load,
    input  logic              watch,
    output logic [DATA_W-1:0] cur_word,
    output logic              differs,
    output logic              chg_pulse
);

    logic [DATA_W-1:0] cmp_q;
    logic              diff_q;

    // Purpose: source select and comparison against the last sent word.
    always_comb begin
        cur_word = sel ? src_b : src_a;
        differs  = (cur_word != cmp_q);
    end

    // Purpose: store the word that is being sent.
    always_ff @(posedge clk) begin
        if (!rst_n)    cmp_q <= '0;
        else if (load) cmp_q <= cur_word;
    end

    // Purpose: one-cycle pulse on the onset of a difference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            diff_q    <= 1'b0;
            chg_pulse <= 1'b0;
        end else begin
            diff_q    <= differs;
            chg_pulse <= watch & differs & ~diff_q;
        end
    end

    p_cmp_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cmp_q == $past(cur_word)));

    p_cmp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cmp_q));

    p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chg_pulse |=> !chg_pulse);

    p_pulse_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !watch |=> !chg_pulse);

endmodule

// File: rtl/fs_gap_timer.sv
// Module: counts down the idle gap after a frame completes.
// Assumes: load only with a non-zero length; last_tick marks the final gap cycle.
module fs_gap_timer #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] len,
    output logic             last_tick,
    output logic [GAP_W-1:0] left
);

    localparam logic [GAP_W-1:0] ONE = GAP_W'(1);

    // Purpose: load the gap length, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          left <= '0;
        else if (load)       left <= len;
        else if (left != '0) left <= left - ONE;
    end

    // Purpose: flag the last counted cycle.
    always_comb last_tick = (left == ONE);

    p_load_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (len != '0));

endmodule

// File: rtl/frame_start_ctrl.sv
// Module: top of the frame start controller. Chooses when to strobe a
// frame start under the configured policy, then waits for done and gap.
// Assumes: eng_done is a one-cycle pulse from the shift engine.
module frame_start_ctrl
    import frm_start_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int GAP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_trig_en,
    input  logic              cfg_chg_en,
    input  logic              cfg_src_sel,
    input  logic              cfg_trig_fall,
    input  logic [GAP_W-1:0]  cfg_gap,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic              hw_trig,
    input  logic              eng_done,
    output logic              start_o,
    output logic [DATA_W-1:0] word_o,
    output logic              chg_pulse_o
);

    fs_state_t         state;
    fs_mode_t          mode;
    logic              want;
    logic              fire;
    logic              trig_pend;
    logic              data_diff;
    logic [DATA_W-1:0] sel_word;
    logic              gap_load;
    logic              gap_last;
    logic [GAP_W-1:0]  gap_left;

    fs_trig_edge u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_in  (hw_trig),
        .fall_sel (cfg_trig_fall),
        .enable   (cfg_trig_en),
        .consume  (fire),
        .pending  (trig_pend)
    );

    fs_change_track #(.DATA_W(DATA_W)) u_chg (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_a     (src_a),
        .src_b     (src_b),
        .sel       (cfg_src_sel),
        .load      (fire),
        .watch     (cfg_chg_en),
        .cur_word  (sel_word),
        .differs   (data_diff),
        .chg_pulse (chg_pulse_o)
    );

    fs_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (gap_load),
        .len       (cfg_gap),
        .last_tick (gap_last),
        .left      (gap_left)
    );

    // Purpose: decode the start policy into a start request.
    always_comb begin
        mode = fs_mode_t'({cfg_trig_en, cfg_chg_en});
        case (mode)
            MODE_CONT:   want = 1'b1;
            MODE_CHG:    want = data_diff;
            MODE_TRIG:   want = trig_pend;
            default:     want = trig_pend | data_diff;
        endcase
        fire     = (state == FS_IDLE) && want;
        gap_load = (state == FS_BUSY) && eng_done && (cfg_gap != '0);
    end

    // Purpose: frame sequencing idle -> busy -> gap -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FS_IDLE;
        end else begin
            case (state)
                FS_IDLE: if (fire) state <= FS_BUSY;
                FS_BUSY: if (eng_done) state <= (cfg_gap == '0) ? FS_IDLE : FS_GAP;
                FS_GAP:  if (gap_last) state <= FS_IDLE;
                default: state <= FS_IDLE;
            endcase
        end
    end

    // Purpose: register the start strobe and the word to send.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_o <= 1'b0;
            word_o  <= '0;
        end else begin
            start_o <= fire;
            if (fire) word_o <= sel_word;
        end
    end

    p_strobe_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    p_no_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != FS_IDLE) |=> !start_o);

    p_word_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !start_o |-> $stable(word_o));

    p_gap_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_GAP) |-> (gap_left != '0));

    p_pend_served_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_IDLE && trig_pend && cfg_trig_en) |=> start_o);

endmodule

// File: tb/sim_frame_start_ctrl.sv
module sim_frame_start_ctrl;

    localparam int DW = 16;
    localparam int GW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          trig_en, chg_en, src_sel, trig_fall;
    logic [GW-1:0] gap;
    logic [DW-1:0] a, b;
    logic          hw_trig, done;
    logic          start;
    logic [DW-1:0] word;
    logic          chg;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    frame_start_ctrl #(.DATA_W(DW), .GAP_W(GW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_trig_en(trig_en), .cfg_chg_en(chg_en), .cfg_src_sel(src_sel),
        .cfg_trig_fall(trig_fall), .cfg_gap(gap),
        .src_a(a), .src_b(b), .hw_trig(hw_trig), .eng_done(done),
        .start_o(start), .word_o(word), .chg_pulse_o(chg)
    );

    typedef struct packed {
        logic          sel;
        logic          dn;
        logic [DW-1:0] va;
        logic [DW-1:0] vb;
        logic          e_start;
        logic [DW-1:0] e_word;
        logic          e_chg;
    } vec_t;

    // Change mode, gap 2: one cycle per row (R5, R6, R7).
    localparam int NV = 18;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, 1'b0, 16'h1234, 16'h0000, 1'b1, 16'h1234, 1'b1},
        '{1'b0, 1'b0, 16'h1234, 16'h0000, 1'b0, 16'h1234, 1'b0},
        '{1'b0, 1'b0, 16'h5678, 16'h0000, 1'b0, 16'h1234, 1'b1},
        '{1'b0, 1'b1, 16'h5678, 16'h0000, 1'b0, 16'h1234, 1'b0},
        '{1'b0, 1'b0, 16'h5678, 16'h0000, 1'b0, 16'h1234, 1'b0},
        '{1'b0, 1'b0, 16'h5678, 16'h0000, 1'b0, 16'h1234, 1'b0},
        '{1'b0, 1'b0, 16'h5678, 16'h0000, 1'b1, 16'h5678, 1'b0},
        '{1'b0, 1'b0, 16'h5678, 16'h0000, 1'b0, 16'h5678, 1'b0},
        '{1'b0, 1'b1, 16'h5678, 16'h0000, 1'b0, 16'h5678, 1'b0},
        '{1'b0, 1'b0, 16'h5678, 16'h0000, 1'b0, 16'h5678, 1'b0},
        '{1'b0, 1'b0, 16'h5678, 16'h0000, 1'b0, 16'h5678, 1'b0},
        '{1'b0, 1'b0, 16'h5678, 16'h0000, 1'b0, 16'h5678, 1'b0},
        '{1'b1, 1'b0, 16'h5678, 16'h5678, 1'b0, 16'h5678, 1'b0},
        '{1'b1, 1'b0, 16'h5678, 16'h00AA, 1'b1, 16'h00AA, 1'b1},
        '{1'b1, 1'b1, 16'h5678, 16'h00AA, 1'b0, 16'h00AA, 1'b0},
        '{1'b1, 1'b0, 16'h5678, 16'h00AA, 1'b0, 16'h00AA, 1'b0},
        '{1'b1, 1'b0, 16'h5678, 16'h00AA, 1'b0, 16'h00AA, 1'b0},
        '{1'b1, 1'b0, 16'h5678, 16'h00AA, 1'b0, 16'h00AA, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic te, input logic ce, input logic [GW-1:0] g);
        rst_n = 1'b0; trig_en = te; chg_en = ce; src_sel = 1'b0; trig_fall = 1'b0;
        gap = g; a = '0; b = '0; hw_trig = 1'b0; done = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    task automatic no_start(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            tick();
            check(req, {31'b0, start}, 32'd0);
        end
    endtask

    task automatic pulse_done();
        done = 1'b1;
        tick();
        done = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, comparison register cleared
        do_reset(1'b0, 1'b1, GW'(2));
        check("R1 start", {31'b0, start}, 32'd0);
        check("R1 word", {16'b0, word}, 32'd0);
        check("R1 chg", {31'b0, chg}, 32'd0);
        no_start("R1", 3);

        // Table walk, change mode
        for (int i = 0; i < NV; i++) begin
            src_sel = VECS[i].sel; done = VECS[i].dn;
            a = VECS[i].va; b = VECS[i].vb;
            tick();
            check("R5 start", {31'b0, start}, {31'b0, VECS[i].e_start});
            check("R4 R6 word", {16'b0, word}, {16'b0, VECS[i].e_word});
            check("R7 chg", {31'b0, chg}, {31'b0, VECS[i].e_chg});
        end
        done = 1'b0;

        // R9: trigger disabled, edges ignored
        hw_trig = 1'b1; tick(); check("R9", {31'b0, start}, 32'd0);
        hw_trig = 1'b0; no_start("R9", 5);

        // R3: continuous mode pacing
        do_reset(1'b0, 1'b0, GW'(3));
        a = 16'h0BEE;
        tick();
        check("R3 first start", {31'b0, start}, 32'd1);
        check("R4 word", {16'b0, word}, 32'h0BEE);
        no_start("R4 no done", 6);
        pulse_done();
        check("R3 after done", {31'b0, start}, 32'd0);
        for (int k = 1; k <= 4; k++) begin
            tick();
            check("R3 gap3", {31'b0, start}, (k == 4) ? 32'd1 : 32'd0);
        end
        gap = '0;
        tick();
        pulse_done();
        check("R3 gap0 done", {31'b0, start}, 32'd0);
        tick();
        check("R3 gap0 start", {31'b0, start}, 32'd1);

        // R8 and R2: trigger mode, rising then falling polarity
        do_reset(1'b1, 1'b0, GW'(1));
        a = 16'h00C3;
        no_start("R2 trig-only ignores data", 3);
        check("R2 no chg pulse", {31'b0, chg}, 32'd0);
        hw_trig = 1'b1;
        tick(); check("R8 rise +1", {31'b0, start}, 32'd0);
        tick(); check("R8 rise +2", {31'b0, start}, 32'd1);
        check("R8 word", {16'b0, word}, 32'h00C3);
        tick();
        pulse_done();
        no_start("R8 level held", 4);
        hw_trig = 1'b0;
        no_start("R8 wrong edge", 4);
        trig_fall = 1'b1;
        tick();
        hw_trig = 1'b1;
        no_start("R8 rise ignored", 4);
        hw_trig = 1'b0;
        tick(); check("R8 fall +1", {31'b0, start}, 32'd0);
        tick(); check("R8 fall +2", {31'b0, start}, 32'd1);

        // R10: trigger during frame held pending
        do_reset(1'b1, 1'b0, GW'(2));
        hw_trig = 1'b1;
        tick(); tick();
        check("R10 first", {31'b0, start}, 32'd1);
        hw_trig = 1'b0; tick();
        hw_trig = 1'b1; tick();
        no_start("R10 held", 3);
        pulse_done();
        check("R10 done", {31'b0, start}, 32'd0);
        for (int k = 1; k <= 3; k++) begin
            tick();
            check("R10 served", {31'b0, start}, (k == 3) ? 32'd1 : 32'd0);
        end
        tick();
        pulse_done();
        no_start("R10 single", 5);

        // R11: either trigger or change
        do_reset(1'b1, 1'b1, GW'(0));
        no_start("R11 quiet", 1);
        a = 16'h0F0F;
        tick();
        check("R11 change", {31'b0, start}, 32'd1);
        check("R11 word", {16'b0, word}, 32'h0F0F);
        pulse_done();
        no_start("R11 settled", 2);
        hw_trig = 1'b1;
        tick(); check("R11 trig +1", {31'b0, start}, 32'd0);
        tick(); check("R11 trig +2", {31'b0, start}, 32'd1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule